// File: doc/BRIEF.md
# DS3 Transmit Frame Alignment Tracker

This block keeps track of where the transmitter is within the 4760-bit DS3 M-frame, one bit per transmit clock. The frame is built from 7 subframes of 680 bits. Each subframe holds 8 blocks of 85 bits, and each block is one overhead bit followed by 84 payload bits. From the current position the block produces three outputs: a gapped clock enable that drops on every overhead bit, a one-clock insertion strobe on selected overhead positions (for example the three C-bits of the fourth subframe, used to insert far-end error bits), and a frame-start pulse or overhead mark for downstream logic.

The block has two alignment modes. In external mode, a sync line is sampled on the falling clock edge. A low sample followed by a high sample marks the current bit time as bit 0 of a frame. Alignment is then held without further pulses. A later edge that lands where the frame start is already predicted changes nothing, and an edge anywhere else re-aligns the counter at once. Until the first edge the block reports unlocked and holds the gapped clock and the insertion strobe low. In self-timed mode the counter starts at bit 0 when reset is released and runs freely, so the block is locked at once.

Top module: `ds3_tx_align`

## Requirements
- R1: In external mode after reset, and until the first sync edge, locked_o, gap_en_o and ins_o are all 0 and sync_o is 0.
- R2: In external mode, sync_i is sampled on the falling clock edge. A high sample whose previous sample was low makes that bit time frame bit 0, so the next bit time is frame bit 1 and the first 85-bit block continues from there.
- R3: Once locked in external mode, the frame position advances by one per clock and wraps from 4759 to 0, with no further sync edges needed. locked_o stays 1 until reset.
- R4: A sync edge in the bit time the block already counts as frame bit 0 leaves the alignment unchanged. Holding sync_i high over several clocks produces no further edges.
- R5: A sync edge at any other position makes that bit time frame bit 0 at once.
- R6: While locked, gap_en_o is 0 on every bit whose position modulo 85 is 0 (overhead) and 1 on every other bit.
- R7: While locked, ins_o is 1 for exactly the single bit at position 680*s + 85*k when ins_sf_sel_i[s] and ins_slot_sel_i[k] are both 1 (s = subframe 0..6, k = overhead slot 0..7 in the order X/P/M, F1, C1, F2, C2, F3, C3, F4). ins_o is 0 on all payload bits.
- R8: In self-timed mode (sync_in_mode_i = 0), locked_o is 1 and the bit time right after reset release is frame bit 0. sync_i has no effect in this mode.
- R9: In self-timed mode with mark_mode_i = 0, sync_o is 1 only on frame bit 0.
- R10: In self-timed mode with mark_mode_i = 1, sync_o is 1 on every overhead bit (position modulo 85 equal to 0) and 0 on payload bits.
- R11: In external mode, sync_o is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | External frame sync, sampled on the falling edge |
| sync_in_mode_i | input | 1 | 1 = align to sync_i, 0 = self-timed with sync_o driven |
| mark_mode_i | input | 1 | Self-timed sync_o type: 0 = frame-start pulse, 1 = overhead mark |
| ins_sf_sel_i | input | 7 | Subframe select for the insertion strobe |
| ins_slot_sel_i | input | 8 | Overhead slot select for the insertion strobe |
| gap_en_o | output | 1 | Gapped clock enable, low on overhead bits and while unlocked |
| ins_o | output | 1 | Overhead insertion strobe |
| sync_o | output | 1 | Frame-start pulse or overhead mark in self-timed mode |
| locked_o | output | 1 | Frame alignment established |

## Verification
The assertions assume that the mode and mark selects change only while reset is asserted. The bench sets them inside its reset task and holds them for the whole run that follows. The assertions also assume that sync_i is steady around each falling edge. The stimulus changes sync_i one time unit after each rising edge, so it is stable at the sampling point. Sync edges are placed in three ways: at random positions, at the exact predicted frame start, and as pulses held high over several clocks.

// File: rtl/ds3_tx_pkg.sv
package ds3_tx_pkg;
  localparam int BLK_BITS  = 85;
  localparam int SLOTS     = 8;
  localparam int SUBFRAMES = 7;
  localparam int BLK_W     = $clog2(BLK_BITS);
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int SF_W      = $clog2(SUBFRAMES);

  typedef struct packed {
    logic [SF_W-1:0]   sf;
    logic [SLOT_W-1:0] slot;
    logic [BLK_W-1:0]  blk;
  } frame_pos_t;
endpackage

// File: rtl/ds3_sync_sampler.sv
module ds3_sync_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic edge_o
);
  logic prev_q, edge_q;

  // falling-edge sampling; edge_q spans the posedge that closes the bit time
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      edge_q <= sync_i & ~prev_q;
    end
  end

  assign edge_o = edge_q;

  assert_edge_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/ds3_frame_counter.sv
module ds3_frame_counter
  import ds3_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_free_i,
  input  logic       load_i,
  output frame_pos_t pos_o,
  output logic       locked_o
);
  frame_pos_t pos_q, pos_nxt;
  logic       locked_q;

  always_comb begin
    pos_nxt = pos_q;
    if (pos_q.blk == BLK_W'(BLK_BITS - 1)) begin
      pos_nxt.blk = '0;
      if (pos_q.slot == SLOT_W'(SLOTS - 1)) begin
        pos_nxt.slot = '0;
        pos_nxt.sf   = (pos_q.sf == SF_W'(SUBFRAMES - 1)) ? '0 : pos_q.sf + 1'b1;
      end else begin
        pos_nxt.slot = pos_q.slot + 1'b1;
      end
    end else begin
      pos_nxt.blk = pos_q.blk + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else if (load_i) begin
      // edge bit time was frame bit 0
      pos_q    <= '{sf: '0, slot: '0, blk: BLK_W'(1)};
      locked_q <= 1'b1;
    end else if (locked_q || run_free_i) begin
      pos_q    <= pos_nxt;
    end
  end

  assign pos_o    = pos_q;
  assign locked_o = locked_q | run_free_i;

  assert_hold_unlocked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o && !load_i |=> $stable(pos_q));
  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pos_q.blk == BLK_W'(1)) && (pos_q.slot == '0) && (pos_q.sf == '0));
endmodule

// File: rtl/ds3_oh_decode.sv
module ds3_oh_decode
  import ds3_tx_pkg::*;
(
  input  frame_pos_t           pos_i,
  input  logic                 locked_i,
  input  logic                 drive_sync_i,
  input  logic                 mark_mode_i,
  input  logic [SUBFRAMES-1:0] sf_sel_i,
  input  logic [SLOTS-1:0]     slot_sel_i,
  output logic                 gap_en_o,
  output logic                 ins_o,
  output logic                 sync_o
);
  logic oh_bit, frame_start;

  assign oh_bit      = (pos_i.blk == '0);
  assign frame_start = oh_bit && (pos_i.slot == '0) && (pos_i.sf == '0);

  assign gap_en_o = locked_i && !oh_bit;
  assign ins_o    = locked_i && oh_bit && sf_sel_i[pos_i.sf] && slot_sel_i[pos_i.slot];
  assign sync_o   = drive_sync_i && (mark_mode_i ? oh_bit : frame_start);
endmodule

// File: rtl/ds3_tx_align.sv
module ds3_tx_align
  import ds3_tx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic                 sync_in_mode_i,
  input  logic                 mark_mode_i,
  input  logic [SUBFRAMES-1:0] ins_sf_sel_i,
  input  logic [SLOTS-1:0]     ins_slot_sel_i,
  output logic                 gap_en_o,
  output logic                 ins_o,
  output logic                 sync_o,
  output logic                 locked_o
);
  logic       sync_edge, load;
  frame_pos_t pos;
  logic       locked;

  ds3_sync_sampler u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .edge_o (sync_edge)
  );

  assign load = sync_edge & sync_in_mode_i;

  ds3_frame_counter u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_free_i (~sync_in_mode_i),
    .load_i     (load),
    .pos_o      (pos),
    .locked_o   (locked)
  );

  ds3_oh_decode u_decode (
    .pos_i        (pos),
    .locked_i     (locked),
    .drive_sync_i (~sync_in_mode_i),
    .mark_mode_i  (mark_mode_i),
    .sf_sel_i     (ins_sf_sel_i),
    .slot_sel_i   (ins_slot_sel_i),
    .gap_en_o     (gap_en_o),
    .ins_o        (ins_o),
    .sync_o       (sync_o)
  );

  assign locked_o = locked;

  assert_quiet_unlocked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> !gap_en_o && !ins_o);
  assert_payload_after_oh_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && !gap_en_o |=> gap_en_o);
  assert_ins_not_payload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> !gap_en_o);
  assert_self_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_in_mode_i |-> locked_o);
  assert_pulse_then_payload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o && !mark_mode_i |=> gap_en_o && !sync_o);
  assert_mark_on_oh_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> !gap_en_o);
  assert_sync_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_in_mode_i |-> !sync_o);
endmodule

// File: tb/ds3_tx_align_tb.sv
`timescale 1ns/1ps
module ds3_tx_align_tb;
  localparam int FRAME = 4760;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic       in_mode = 1'b1;
  logic       mark = 1'b0;
  logic [6:0] sf_sel = 7'b0001000;
  logic [7:0] slot_sel = 8'b01010100;
  logic       gap_en_o, ins_o, sync_o, locked_o;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string ph = "R1";

  int m_pos;
  bit m_lk;
  bit m_prev;

  always #5 clk = ~clk;

  ds3_tx_align u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .sync_i         (sync_i),
    .sync_in_mode_i (in_mode),
    .mark_mode_i    (mark),
    .ins_sf_sel_i   (sf_sel),
    .ins_slot_sel_i (slot_sel),
    .gap_en_o       (gap_en_o),
    .ins_o          (ins_o),
    .sync_o         (sync_o),
    .locked_o       (locked_o)
  );

  function automatic bit e_gap(int p, bit lk);
    return lk && (p % 85 != 0);
  endfunction

  function automatic bit e_ins(int p, bit lk);
    return lk && (p % 85 == 0) && sf_sel[p / 680] && slot_sel[(p / 85) % 8];
  endfunction

  function automatic bit e_sync(int p);
    if (in_mode) return 1'b0;
    return mark ? (p % 85 == 0) : (p == 0);
  endfunction

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [phase %s] pos=%0d actual=%0b expected=%0b", req, ph, m_pos, act, exp);
    end
  endtask

  task automatic check_outs();
    chk(locked_o, m_lk, in_mode ? "R3 locked" : "R8 locked");
    chk(gap_en_o, e_gap(m_pos, m_lk), m_lk ? "R6 gap" : "R1 gap");
    chk(ins_o, e_ins(m_pos, m_lk), m_lk ? "R7 ins" : "R1 ins");
    chk(sync_o, e_sync(m_pos), in_mode ? "R11 sync" : (mark ? "R10 sync" : "R9 sync"));
  endtask

  task automatic advance(input bit v);
    bit edge_s;
    edge_s = v && !m_prev;
    m_prev = v;
    if (in_mode && edge_s) begin
      m_pos = 1;
      m_lk  = 1'b1;
    end else if (m_lk) begin
      m_pos = (m_pos + 1) % FRAME;
    end
  endtask

  task automatic step(input bit v);
    @(posedge clk);
    #1 sync_i = v;
    #3 check_outs();
    advance(v);
  endtask

  task automatic do_reset(input bit im, input bit mk);
    rst_ni  = 1'b0;
    in_mode = im;
    mark    = mk;
    sync_i  = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    m_pos  = 0;
    m_lk   = !im;
    m_prev = 1'b0;
    #3 check_outs();
    advance(1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic pulse(input int w);
    for (int i = 0; i < w; i++) step(1'b1);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'h1d53);
    // R1: unlocked, quiet, FEBE mask (subframe index 3, C-bit slots 2/4/6)
    ph = "R1";
    do_reset(1'b1, 1'b0);
    idle(300);
    // R2: first edge at an arbitrary point
    ph = "R2";
    pulse(1);
    idle(1000);
    // R3: hold over two frames with no pulses
    ph = "R3";
    idle(2 * FRAME);
    // R4: edges on the predicted frame start, one held high
    ph = "R4";
    while (m_pos != 0) step(1'b0);
    pulse(20);
    idle(200);
    while (m_pos != 0) step(1'b0);
    pulse(1);
    idle(300);
    // R5: misplaced edges, random widths, random masks
    ph = "R5";
    for (int k = 0; k < 6; k++) begin
      sf_sel   = 7'($urandom());
      slot_sel = 8'($urandom());
      idle(100 + int'($urandom_range(0, 5000)));
      pulse(1 + int'($urandom_range(0, 4)));
    end
    idle(FRAME + 10);
    // R8/R9: self-timed frame pulse, sync_i toggled without effect
    ph = "R8";
    sf_sel   = 7'($urandom());
    slot_sel = 8'($urandom());
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 2 * FRAME + 50; i++) step(1'($urandom()));
    // R10: self-timed overhead mark
    ph = "R10";
    slot_sel = 8'hff;
    sf_sel   = 7'h7f;
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < FRAME + 50; i++) step(1'($urandom()));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule